// File: doc/BRIEF.md
# Split Instruction Fetch Front End with Epoch Filtering

This block is the front of an in-order pipeline. It talks to an instruction memory that accepts one address per handshake and answers later, always in the order of its requests, with an unknown number of cycles between request and answer. The fetch side sends the current program counter and moves it to the predicted next address, a fixed step past the current one. For every request it keeps a small record of the address, the predicted address and a one-bit epoch in a tracking queue.

The decode side matches each memory answer with the oldest record. A redirect from execute loads a corrected program counter and flips the epoch. From then on, every answer whose record carries the old epoch is consumed and thrown away, so fetches already under way are never recalled from memory. Matching answers go out on a valid/ready port unless the hazard stall input holds them back. The check that throws a record away uses the epoch as it will be after a redirect arriving in that same cycle.

Top module: `fetch_split_front`

## Requirements
- R1: After reset the program counter equals RESET_PC, the epoch is 0 and the tracking queue is empty. The memory request is valid at RESET_PC, while `out_valid` and `imem_rsp_ready` are both low.
- R2: Each accepted memory request (`imem_req_valid` and `imem_req_ready` both high) with no redirect moves the request address on by STEP. With no request accepted and no redirect, the address holds.
- R3: `imem_req_valid` is high exactly when fewer than DEPTH requests are awaiting their answers.
- R4: An issued item carries the address of the oldest outstanding request in `out_pc`, that address plus STEP in `out_pred_pc`, the epoch of that request in `out_epoch`, and the answer word in `out_instr`. An issued item that is accepted consumes the answer.
- R5: An answer whose record epoch differs from the live epoch is consumed (`imem_rsp_ready` high) and never shows on the output.
- R6: When the hazard stall is high, `out_valid` and `imem_rsp_ready` are low for a record with a matching epoch, and the pair stays at the head.
- R7: A redirect sets the next request address to `redir_pc` and flips the epoch. This holds even when a request is accepted in the same cycle, and that request keeps the old epoch.
- R8: The live epoch used for the drop check is the flipped value during a redirect cycle, so a head answer with the pre-redirect epoch is dropped in that same cycle.
- R9: While `out_valid` is high and `out_ready` is low, `imem_rsp_ready` stays low and the output fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect from execute |
| redir_pc | input | AW | Corrected program counter |
| imem_req_valid | output | 1 | Memory request offered |
| imem_req_ready | input | 1 | Memory accepts request |
| imem_req_addr | output | AW | Request address |
| imem_rsp_valid | input | 1 | Memory answer offered |
| imem_rsp_ready | output | 1 | Answer consumed |
| imem_rsp_data | input | IW | Instruction word |
| hazard_stall | input | 1 | Decode hazard hold |
| out_valid | output | 1 | Issued item valid |
| out_ready | input | 1 | Downstream accepts item |
| out_pc | output | AW | Address of item |
| out_pred_pc | output | AW | Predicted next address |
| out_epoch | output | 1 | Epoch of item |
| out_instr | output | IW | Instruction word of item |

## Verification
The bench builds the block with DEPTH 4, STEP 4, RESET_PC 0x100 and 32-bit addresses and words. A depth of four lets a few cycles of unanswered requests fill the tracking queue, so the full-queue stop is reached. With a queue that deep, a redirect leaves several stale records to drain one after another. The bench also covers a redirect that lands on the same cycle as an accepted fetch, and one that lands while a stale answer sits at the head.

// File: rtl/fetch_split_front.sv
module fetch_split_front #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DEPTH = 4,
  parameter int STEP = 4,
  parameter logic [AW-1:0] RESET_PC = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_pc,
  output logic          imem_req_valid,
  input  logic          imem_req_ready,
  output logic [AW-1:0] imem_req_addr,
  input  logic          imem_rsp_valid,
  output logic          imem_rsp_ready,
  input  logic [IW-1:0] imem_rsp_data,
  input  logic          hazard_stall,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_pred_pc,
  output logic          out_epoch,
  output logic [IW-1:0] out_instr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] pc_q;
  logic          epoch_q;
  logic [AW-1:0] trk_pc   [DEPTH];
  logic [AW-1:0] trk_pred [DEPTH];
  logic [DEPTH-1:0] trk_ep;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire trk_full  = (count == CW'(DEPTH));
  wire trk_empty = (count == '0);
  wire req_fire  = imem_req_valid && imem_req_ready;
  wire live_ep   = epoch_q ^ redir_valid;
  wire head_stale = trk_ep[rd_ptr] != live_ep;
  wire pop       = imem_rsp_valid && imem_rsp_ready;

  assign imem_req_valid = !trk_full;
  assign imem_req_addr  = pc_q;
  assign imem_rsp_ready = !trk_empty && (head_stale || (!hazard_stall && out_ready));
  assign out_valid      = !trk_empty && imem_rsp_valid && !head_stale && !hazard_stall;
  assign out_pc         = trk_pc[rd_ptr];
  assign out_pred_pc    = trk_pred[rd_ptr];
  assign out_epoch      = trk_ep[rd_ptr];
  assign out_instr      = imem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      epoch_q <= 1'b0;
    end else if (redir_valid) begin
      pc_q    <= redir_pc;
      epoch_q <= ~epoch_q;
    end else if (req_fire) begin
      pc_q    <= pc_q + STEP_V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      trk_ep <= '0;
    end else begin
      if (req_fire) begin
        trk_pc[wr_ptr]   <= pc_q;
        trk_pred[wr_ptr] <= pc_q + STEP_V;
        trk_ep[wr_ptr]   <= epoch_q;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (req_fire && !pop) count <= count + 1'b1;
      else if (pop && !req_fire) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/fetch_split_front_chk.sv
module fetch_split_front_chk #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic          imem_req_valid,
  input logic          imem_req_ready,
  input logic [AW-1:0] imem_req_addr,
  input logic          imem_rsp_valid,
  input logic          imem_rsp_ready,
  input logic          hazard_stall,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_pc,
  input logic [AW-1:0] out_pred_pc
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] outstanding;
  wire rq = imem_req_valid && imem_req_ready;
  wire rs = imem_rsp_valid && imem_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else if (rq && !rs) outstanding <= outstanding + 1'b1;
    else if (rs && !rq) outstanding <= outstanding - 1'b1;
  end

  p_full_stops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding == CW'(DEPTH)) |-> !imem_req_valid);
  p_room_offers_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding < CW'(DEPTH)) |-> imem_req_valid);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq && !redir_valid) |=> imem_req_addr == $past(imem_req_addr) + AW'(STEP));
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rq && !redir_valid) |=> $stable(imem_req_addr));
  p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> imem_req_addr == $past(redir_pc));
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_stall |-> !out_valid);
  p_issue_consumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> imem_rsp_ready);
  p_pred_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pred_pc == out_pc + AW'(STEP));
  p_rsp_tracked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rsp_ready |-> outstanding != '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !imem_rsp_ready);
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_pc) && $stable(out_pred_pc));
endmodule

bind fetch_split_front fetch_split_front_chk #(.AW(AW), .DEPTH(DEPTH), .STEP(STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
  .imem_req_addr(imem_req_addr), .imem_rsp_valid(imem_rsp_valid),
  .imem_rsp_ready(imem_rsp_ready), .hazard_stall(hazard_stall),
  .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
  .out_pred_pc(out_pred_pc)
);

// File: tb/fetch_split_front_tb_top.sv
module fetch_split_front_tb_top;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int DEPTH = 4;
  localparam logic [31:0] RST_PC = 32'h100;
  localparam logic [31:0] REDIR = 32'h800;
  localparam logic [31:0] MASK = 32'hC0DE_0000;
  localparam int NV = 17;
  // {req_rdy, rsp_v, stall, out_rdy, redir, exp_req_v, exp_out_v, exp_rsp_rdy}
  localparam logic [7:0] VEC [NV] = '{
    8'b1001_0100, // first fetch, nothing back (R3)
    8'b1101_0111, // issue (R4)
    8'b0111_0100, // stall holds (R6)
    8'b1100_0110, // out_ready low (R9)
    8'b1101_0111, // issue
    8'b1001_0101, // fill
    8'b1001_0101, // fill to DEPTH
    8'b1001_0001, // full: no request (R3)
    8'b1101_1001, // redirect, same-cycle drop (R8)
    8'b1101_0101, // stale drop (R5)
    8'b0101_0101, // stale drop (R5)
    8'b0111_0101, // stale drop despite stall (R5)
    8'b1101_0111, // new-epoch issue (R4)
    8'b1101_1101, // redirect with fetch same cycle (R7, R8)
    8'b1101_0101, // drop request issued under old epoch
    8'b0101_0111, // issue after second redirect
    8'b0101_0100  // empty
  };

  logic clk = 0, rst_n = 0;
  logic redir_valid = 0, imem_req_ready = 0, imem_rsp_valid = 0;
  logic hazard_stall = 0, out_ready = 0;
  logic [AW-1:0] redir_pc = REDIR;
  logic [IW-1:0] imem_rsp_data = '0;
  logic imem_req_valid, imem_rsp_ready, out_valid, out_epoch;
  logic [AW-1:0] imem_req_addr, out_pc, out_pred_pc;
  logic [IW-1:0] out_instr;

  int checks = 0, errors = 0;
  logic [31:0] q_pc [8];
  logic        q_ep [8];
  int qn = 0;
  logic [31:0] m_pc = RST_PC;
  logic        m_ep = 0;

  always #5 clk = ~clk;

  fetch_split_front #(.AW(AW), .IW(IW), .DEPTH(DEPTH), .STEP(4), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_req_addr(imem_req_addr), .imem_rsp_valid(imem_rsp_valid),
    .imem_rsp_ready(imem_rsp_ready), .imem_rsp_data(imem_rsp_data),
    .hazard_stall(hazard_stall), .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_pred_pc(out_pred_pc), .out_epoch(out_epoch),
    .out_instr(out_instr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prev_redir;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    chk("R1", imem_req_valid, 1);
    chk("R1", imem_req_addr, RST_PC);
    chk("R1", out_valid, 0);
    chk("R1", imem_rsp_ready, 0);
    prev_redir = 0;
    for (int i = 0; i < NV; i++) begin
      logic fire, popv;
      logic [7:0] v;
      v = VEC[i];
      @(negedge clk);
      imem_req_ready = v[7];
      imem_rsp_valid = v[6] && (qn > 0);
      hazard_stall   = v[5];
      out_ready      = v[4];
      redir_valid    = v[3];
      imem_rsp_data  = (qn > 0) ? (q_pc[0] ^ MASK) : '0;
      #2;
      chk("R3", imem_req_valid, v[2]);
      if (imem_req_valid) chk(prev_redir ? "R7" : "R2", imem_req_addr, m_pc);
      chk(v[3] ? "R8" : "R6", out_valid, v[1]);
      chk(v[4] ? "R5" : "R9", imem_rsp_ready, v[0]);
      if (v[1]) begin
        chk("R4", out_pc, q_pc[0]);
        chk("R4", out_pred_pc, q_pc[0] + 4);
        chk("R4", out_epoch, q_ep[0]);
        chk("R4", out_instr, q_pc[0] ^ MASK);
      end
      fire = imem_req_valid && imem_req_ready;
      popv = imem_rsp_valid && imem_rsp_ready;
      @(posedge clk);
      if (popv) begin
        for (int k = 0; k < 7; k++) begin q_pc[k] = q_pc[k+1]; q_ep[k] = q_ep[k+1]; end
        qn--;
      end
      if (fire) begin q_pc[qn] = m_pc; q_ep[qn] = m_ep; qn++; end
      if (v[3]) begin m_pc = REDIR; m_ep = ~m_ep; end
      else if (fire) m_pc = m_pc + 4;
      prev_redir = v[3];
    end
    // R9 directed: offered item held for two cycles with out_ready low
    @(negedge clk);
    redir_valid = 0; hazard_stall = 0; out_ready = 0; imem_req_ready = 1;
    imem_rsp_valid = 0;
    @(negedge clk);
    imem_req_ready = 0;
    imem_rsp_valid = 1;
    imem_rsp_data = m_pc ^ MASK;
    #2;
    chk("R9", out_valid, 1);
    chk("R4", out_epoch, m_ep);
    chk("R9", out_pc, m_pc);
    @(negedge clk);
    #2;
    chk("R9", out_valid, 1);
    chk("R9", imem_rsp_ready, 0);
    chk("R9", out_pc, m_pc);
    @(negedge clk);
    out_ready = 1;
    #2;
    chk("R4", imem_rsp_ready, 1);
    @(negedge clk);
    imem_rsp_valid = 0;
    #2;
    chk("R4", out_valid, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule